// File: doc/BRIEF.md
# PHY-Side Link Interface Start-Up Sequencer

This block sits on the physical-layer side of the parallel interface between a PHY and its link controller. It brings that interface back to normal operation after a reset or a power-down. While the link holds its power-status input low, the block stays quiet. A free-running reference-clock counter measures how long that quiet period lasts. Once the quiet period has been long enough and the link raises power status again, the block starts the system clock toward the link. It then steps the control and data lines through a fixed start-up waveform: a low phase, a Receive indication carrying all ones, and finally Idle. When Idle is reached, a ready flag opens the path for link requests.

A mode pin selects one of two start-up waveforms. In differentiated mode (pin low), the system clock is held low for half a period before the first full cycle. The lines are driven low for one cycle only, and they float again after the first Receive cycle. In non-differentiated mode (pin high), the lines stay driven for the whole sequence. The system clock is derived from the reference clock, with a period of `2*HALF_DIV` reference cycles. All sequence positions are counted in whole system-clock cycles.

No data stream crosses this block. Its pins are plain control and status lines, so there is no valid/ready handshake and no back-pressure. A request from the link is reported only while the ready flag is high. All inputs are assumed synchronous to the reference clock.

Top module: `phy_link_init`

## Requirements
- R1: While reset is asserted, and after it is released until a sequence starts, `lines_oe_o`, `sysclk_o`, `ready_o` and `lreq_accept_o` are all 0.
- R2: A sequence starts only when `lps_i` is sampled high after at least `RESTORE_CYC` consecutive low samples taken while the block is off. If `lps_i` is high earlier, it is ignored and the low count restarts from zero.
- R3: The system clock runs with a period of `2*HALF_DIV` reference cycles. Each cycle is high for its first `HALF_DIV` reference cycles and low for the rest. In non-differentiated mode, cycle 1 begins on the reference cycle after the start sample. In differentiated mode, cycle 1 is preceded by `HALF_DIV` reference cycles of low clock.
- R4: In differentiated mode, `ctl_o=2'b00` and `d_o=0` are driven (`lines_oe_o=1`) during system-clock cycle 1. The lines float (`lines_oe_o=0`) during cycles 2 to 7.
- R5: In non-differentiated mode, `ctl_o=2'b00` and `d_o=0` are driven during system-clock cycles 1 to 7.
- R6: Cycles 8 to `7+RX_CYCLES` carry Receive (`ctl_o=2'b10`) with `d_o` all ones. Non-differentiated mode drives all of these cycles. Differentiated mode drives only cycle 8 and floats the rest.
- R7: From cycle `8+RX_CYCLES` onward, the block drives Idle (`ctl_o=2'b00`, `d_o=0`) and holds `ready_o=1`, and the system clock keeps running.
- R8: `lreq_accept_o` equals `lreq_i` while `ready_o` is 1, and is 0 otherwise.
- R9: Whenever the block is not off and `lps_i` is sampled low, the block is off on the next reference cycle: lines floating, clock low, ready cleared. A fresh restore period is then required.
- R10: The mode pin is latched when a sequence starts, and later changes have no effect on it. While the block is off, `sysclk_oe_o` follows the mode pin: it is 1 (clock driven low) when the pin is high and 0 (floating) when it is low. Once a sequence starts, `sysclk_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lps_i | input | 1 | Link power status from the link controller |
| iso_mode_i | input | 1 | Mode pin: 1 = non-differentiated, 0 = differentiated |
| lreq_i | input | 1 | Request line from the link controller |
| sysclk_o | output | 1 | System clock toward the link |
| sysclk_oe_o | output | 1 | Drive enable for the system clock pin |
| ctl_o | output | 2 | Control line value (00 Idle, 10 Receive) |
| d_o | output | D_W | Data line value |
| lines_oe_o | output | 1 | Drive enable shared by the control and data lines |
| ready_o | output | 1 | Start-up complete, requests are accepted |
| lreq_accept_o | output | 1 | Request seen while ready |

## Verification
The bench builds the block with `HALF_DIV=2`, `RESTORE_CYC=10` and `RX_CYCLES=2`. A four-reference-cycle system clock makes the half-period preamble, the high/low split and every cycle boundary visible as separate reference cycles. A short restore count makes both premature and valid power-status rises reachable within a few dozen cycles. Two Receive cycles separate the driven-versus-floating behaviour of the two modes after the first Receive cycle.

// File: rtl/lnk_init_pkg.sv
package lnk_init_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_PRE   = 2'd1,
    ST_RUN   = 2'd2,
    ST_READY = 2'd3
  } seq_st_t;

  localparam int CTL_W = 2;
  localparam logic [CTL_W-1:0] CTL_IDLE = 2'b00;
  localparam logic [CTL_W-1:0] CTL_RECV = 2'b10;

  localparam int LOW_LAST_CYC = 7;
  localparam int RX_FIRST_CYC = 8;

endpackage

// File: rtl/lnk_restore_timer.sv
module lnk_restore_timer #(
  parameter int RESTORE_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic lps_i,
  output logic armed_o
);
  localparam int CNT_W = $clog2(RESTORE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RESTORE_CYC);

  logic [CNT_W-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
    end else if (hold_i) begin
      quiet_cnt <= '0;
    end else if (quiet_cnt != CNT_MAX) begin
      if (lps_i) quiet_cnt <= '0;
      else       quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  assign armed_o = (quiet_cnt == CNT_MAX);

endmodule

// File: rtl/lnk_seq_ctrl.sv
module lnk_seq_ctrl
  import lnk_init_pkg::*;
#(
  parameter int HALF_DIV  = 1,
  parameter int RX_CYCLES = 1,
  localparam int PH_W     = $clog2(2 * HALF_DIV),
  localparam int LAST_CYC = RX_FIRST_CYC + RX_CYCLES - 1,
  localparam int CYC_W    = $clog2(LAST_CYC + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lps_i,
  input  logic             iso_mode_i,
  input  logic             armed_i,
  output seq_st_t          state_o,
  output logic [PH_W-1:0]  ph_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic             mode_o
);
  localparam logic [PH_W-1:0]  PH_WRAP = PH_W'(2 * HALF_DIV - 1);
  localparam logic [PH_W-1:0]  PH_PRE  = PH_W'(HALF_DIV - 1);
  localparam logic [CYC_W-1:0] CYC_END = CYC_W'(LAST_CYC);

  seq_st_t          st_q, st_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             mode_q, mode_d;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    cyc_d  = cyc_q;
    mode_d = mode_q;
    if (st_q != ST_OFF && !lps_i) begin
      st_d  = ST_OFF;
      ph_d  = '0;
      cyc_d = '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          if (lps_i && armed_i) begin
            mode_d = iso_mode_i;
            ph_d   = '0;
            cyc_d  = CYC_W'(1);
            st_d   = iso_mode_i ? ST_RUN : ST_PRE;
          end
        end
        ST_PRE: begin
          if (ph_q == PH_PRE) begin
            ph_d = '0;
            st_d = ST_RUN;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (ph_q == PH_WRAP) begin
            ph_d = '0;
            if (cyc_q == CYC_END) st_d = ST_READY;
            else                  cyc_d = cyc_q + 1'b1;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        ST_READY: begin
          ph_d = (ph_q == PH_WRAP) ? '0 : ph_q + 1'b1;
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      ph_q   <= '0;
      cyc_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cyc_q  <= cyc_d;
      mode_q <= mode_d;
    end
  end

  assign state_o = st_q;
  assign ph_o    = ph_q;
  assign cyc_o   = cyc_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/lnk_line_drv.sv
module lnk_line_drv
  import lnk_init_pkg::*;
#(
  parameter int HALF_DIV  = 1,
  parameter int RX_CYCLES = 1,
  parameter int D_W       = 8,
  localparam int PH_W     = $clog2(2 * HALF_DIV),
  localparam int LAST_CYC = RX_FIRST_CYC + RX_CYCLES - 1,
  localparam int CYC_W    = $clog2(LAST_CYC + 2)
) (
  input  seq_st_t          state_i,
  input  logic [PH_W-1:0]  ph_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic             mode_i,
  input  logic             iso_live_i,
  output logic             sysclk_o,
  output logic             sysclk_oe_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic [D_W-1:0]   d_o,
  output logic             lines_oe_o,
  output logic             ready_o
);
  localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(HALF_DIV);
  localparam logic [CYC_W-1:0] CYC_ONE  = CYC_W'(1);
  localparam logic [CYC_W-1:0] CYC_LOWE = CYC_W'(LOW_LAST_CYC);
  localparam logic [CYC_W-1:0] CYC_RX1  = CYC_W'(RX_FIRST_CYC);

  logic clk_live;
  assign clk_live    = (state_i == ST_RUN) || (state_i == ST_READY);
  assign sysclk_o    = clk_live && (ph_i < PH_HALF);
  assign sysclk_oe_o = (state_i != ST_OFF) || iso_live_i;
  assign ready_o     = (state_i == ST_READY);

  always_comb begin
    ctl_o      = CTL_IDLE;
    d_o        = '0;
    lines_oe_o = 1'b0;
    unique case (state_i)
      ST_RUN: begin
        if (cyc_i <= CYC_LOWE) begin
          lines_oe_o = mode_i || (cyc_i == CYC_ONE);
        end else begin
          ctl_o      = CTL_RECV;
          d_o        = '1;
          lines_oe_o = mode_i || (cyc_i == CYC_RX1);
        end
      end
      ST_READY: lines_oe_o = 1'b1;
      default:  lines_oe_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/phy_link_init.sv
module phy_link_init
  import lnk_init_pkg::*;
#(
  parameter int HALF_DIV    = 1,
  parameter int RESTORE_CYC = 500,
  parameter int RX_CYCLES   = 1,
  parameter int D_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lps_i,
  input  logic             iso_mode_i,
  input  logic             lreq_i,
  output logic             sysclk_o,
  output logic             sysclk_oe_o,
  output logic [1:0]       ctl_o,
  output logic [D_W-1:0]   d_o,
  output logic             lines_oe_o,
  output logic             ready_o,
  output logic             lreq_accept_o
);
  localparam int PH_W     = $clog2(2 * HALF_DIV);
  localparam int LAST_CYC = RX_FIRST_CYC + RX_CYCLES - 1;
  localparam int CYC_W    = $clog2(LAST_CYC + 2);

  seq_st_t          state;
  logic [PH_W-1:0]  ph;
  logic [CYC_W-1:0] cyc;
  logic             mode;
  logic             armed;

  lnk_restore_timer #(.RESTORE_CYC(RESTORE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (state != ST_OFF),
    .lps_i   (lps_i),
    .armed_o (armed)
  );

  lnk_seq_ctrl #(.HALF_DIV(HALF_DIV), .RX_CYCLES(RX_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lps_i      (lps_i),
    .iso_mode_i (iso_mode_i),
    .armed_i    (armed),
    .state_o    (state),
    .ph_o       (ph),
    .cyc_o      (cyc),
    .mode_o     (mode)
  );

  lnk_line_drv #(.HALF_DIV(HALF_DIV), .RX_CYCLES(RX_CYCLES), .D_W(D_W)) u_drv (
    .state_i     (state),
    .ph_i        (ph),
    .cyc_i       (cyc),
    .mode_i      (mode),
    .iso_live_i  (iso_mode_i),
    .sysclk_o    (sysclk_o),
    .sysclk_oe_o (sysclk_oe_o),
    .ctl_o       (ctl_o),
    .d_o         (d_o),
    .lines_oe_o  (lines_oe_o),
    .ready_o     (ready_o)
  );

  assign lreq_accept_o = ready_o && lreq_i;

endmodule

// File: rtl/lnk_init_chk.sv
module lnk_init_chk #(
  parameter int D_W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           lps_i,
  input logic           lreq_i,
  input logic           sysclk_o,
  input logic           sysclk_oe_o,
  input logic [1:0]     ctl_o,
  input logic [D_W-1:0] d_o,
  input logic           lines_oe_o,
  input logic           ready_o,
  input logic           lreq_accept_o
);
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (lines_oe_o && ctl_o == 2'b00 && d_o == '0 && sysclk_oe_o));

  p_accept_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_accept_o |-> (ready_o && lreq_i));

  p_drop_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !lps_i) |=> (!ready_o && !lines_oe_o && !sysclk_o));

  p_low_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lps_i |=> !ready_o);

  p_recv_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lines_oe_o && ctl_o == 2'b10) |-> (d_o == '1));

  p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lines_oe_o && ctl_o == 2'b00) |-> (d_o == '0));

  p_ready_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(lps_i));

  p_clk_needs_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sysclk_o |-> sysclk_oe_o);

endmodule

bind phy_link_init lnk_init_chk #(.D_W(D_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lps_i         (lps_i),
  .lreq_i        (lreq_i),
  .sysclk_o      (sysclk_o),
  .sysclk_oe_o   (sysclk_oe_o),
  .ctl_o         (ctl_o),
  .d_o           (d_o),
  .lines_oe_o    (lines_oe_o),
  .ready_o       (ready_o),
  .lreq_accept_o (lreq_accept_o)
);

// File: tb/sim_phy_link_init.sv
`timescale 1ns/1ps
module sim_phy_link_init;
  localparam int HALF = 2;
  localparam int RST  = 10;
  localparam int RX   = 2;
  localparam int DW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lps_i = 1'b0;
  logic iso_mode_i = 1'b1;
  logic lreq_i = 1'b0;
  logic sysclk_o, sysclk_oe_o, lines_oe_o, ready_o, lreq_accept_o;
  logic [1:0] ctl_o;
  logic [DW-1:0] d_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  phy_link_init #(.HALF_DIV(HALF), .RESTORE_CYC(RST), .RX_CYCLES(RX), .D_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .lps_i(lps_i), .iso_mode_i(iso_mode_i), .lreq_i(lreq_i),
    .sysclk_o(sysclk_o), .sysclk_oe_o(sysclk_oe_o), .ctl_o(ctl_o), .d_o(d_o),
    .lines_oe_o(lines_oe_o), .ready_o(ready_o), .lreq_accept_o(lreq_accept_o)
  );

  // behavioural reference: on/off flag, time since start, quiet count
  bit m_on = 0;
  bit m_mode = 0;
  int m_t = 0;
  int m_quiet = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_t = 0; m_quiet = 0;
    end else if (!m_on) begin
      if (!lps_i) begin
        if (m_quiet < RST) m_quiet++;
      end else if (m_quiet >= RST) begin
        m_on = 1; m_t = 0; m_mode = iso_mode_i;
      end else begin
        m_quiet = 0;
      end
    end else if (!lps_i) begin
      m_on = 0; m_quiet = 0;
    end else begin
      m_t++;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      int e_sys, e_oe, e_ctl, e_d, e_rdy, e_soe, k, c;
      string tag;
      e_sys = 0; e_oe = 0; e_ctl = 0; e_d = 0; e_rdy = 0;
      e_soe = iso_mode_i;
      tag = "R2";
      if (m_on) begin
        e_soe = 1;
        k = m_t - (m_mode ? 0 : HALF);
        if (k < 0) begin
          tag = "R3";
        end else begin
          c = k / (2 * HALF) + 1;
          e_sys = ((k % (2 * HALF)) < HALF) ? 1 : 0;
          if (c <= 7) begin
            tag = m_mode ? "R5" : "R4";
            e_oe = (m_mode || c == 1) ? 1 : 0;
          end else if (c <= 7 + RX) begin
            tag = "R6";
            e_oe = (m_mode || c == 8) ? 1 : 0;
            e_ctl = 2; e_d = 255;
          end else begin
            tag = "R7";
            e_oe = 1; e_rdy = 1;
          end
        end
      end
      chk("R3", "sysclk", int'(sysclk_o), e_sys);
      chk(tag, "lines_oe", int'(lines_oe_o), e_oe);
      if (e_oe == 1) begin
        chk(tag, "ctl", int'(ctl_o), e_ctl);
        chk(tag, "d", int'(d_o), e_d);
      end
      chk(tag, "ready", int'(ready_o), e_rdy);
      chk("R8", "accept", int'(lreq_accept_o), e_rdy & int'(lreq_i));
      chk("R10", "sysclk_oe", int'(sysclk_oe_o), e_soe);
    end
  end

  // request line pattern
  int lf = 32'h1d3;
  always @(posedge clk) begin
    #1;
    lf = (lf >> 1) ^ ((lf & 1) ? 32'hb400 : 0);
    lreq_i = lf[0];
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    step(3);
    @(negedge clk);
    chk("R1", "reset oe", int'(lines_oe_o), 0);
    chk("R1", "reset sysclk", int'(sysclk_o), 0);
    chk("R1", "reset ready", int'(ready_o), 0);
    chk("R10", "off sysclk_oe mode high", int'(sysclk_oe_o), 1);
    step(1);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    // premature rises: ignored (R2)
    lps_i = 1'b1; step(5);
    lps_i = 1'b0; step(6);
    lps_i = 1'b1; step(3);
    @(negedge clk);
    chk("R2", "early lps ignored ready", int'(ready_o), 0);
    chk("R2", "early lps ignored clk oe", int'(lines_oe_o), 0);
    // full non-differentiated sequence
    step(0);
    lps_i = 1'b0; step(12);
    lps_i = 1'b1; step(50);
    @(negedge clk);
    chk("R7", "nondiff ready", int'(ready_o), 1);
    // drop in ready
    step(0);
    lps_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9", "drop ready", int'(ready_o), 0);
    chk("R9", "drop oe", int'(lines_oe_o), 0);
    chk("R9", "drop sysclk", int'(sysclk_o), 0);
    // differentiated sequence, mode pin flips after start
    iso_mode_i = 1'b0;
    step(1);
    @(negedge clk);
    chk("R10", "off sysclk_oe mode low", int'(sysclk_oe_o), 0);
    step(12);
    lps_i = 1'b1;
    step(7);
    iso_mode_i = 1'b1;
    step(4);
    @(negedge clk);
    chk("R10", "latched mode keeps lines floating", int'(lines_oe_o), 0);
    step(40);
    @(negedge clk);
    chk("R7", "diff ready", int'(ready_o), 1);
    // differentiated sequence dropped midway
    step(0);
    iso_mode_i = 1'b0;
    lps_i = 1'b0; step(12);
    lps_i = 1'b1; step(20);
    lps_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9", "mid drop oe", int'(lines_oe_o), 0);
    chk("R9", "mid drop sysclk", int'(sysclk_o), 0);
    step(5);
    lps_i = 1'b1; step(4);
    @(negedge clk);
    chk("R9", "restore needed again", int'(sysclk_o), 0);
    step(0);
    lps_i = 1'b0; step(12);
    lps_i = 1'b1; step(45);
    finish_run();
  end

endmodule